// File: doc/BRIEF.md
# Rate and Square-Wave Interval Counter

One counting channel of a programmable interval timer. It produces one of two periodic waveforms from a 16-bit initial count N. In rate mode the output drops low for one count interval every N count edges. In square-wave mode the output is high for about half of each N-edge period and low for the rest. Software first writes the waveform mode and then writes the count. A gate input can pause counting or restart it. A new count written while the channel is running takes effect only at the natural cycle or half-cycle boundary, unless a gate restart comes first.

All logic runs on a single system clock. A one-cycle `cnt_en` pulse stands in for each counting edge. Gate edges are found by comparing `gate` with a registered copy of itself.

The controller has three states: `ST_IDLE`, `ST_ARMED` and `ST_RUN`.

- `ST_IDLE`: entered on reset or on a mode write. No count is held and the output is forced high.
- `ST_IDLE` to `ST_ARMED`: taken on a count write.
- `ST_ARMED` to `ST_RUN`: taken on the next count edge, which also loads the counting element.
- Any state to `ST_IDLE`: taken on a mode write.

Top module: `ivt_wave_chan`

## Requirements
- R1: After reset, and in the clock after any mode write, `tmr_out` is high. `mode_sq`=0 selects rate mode and `mode_sq`=1 selects square mode.
- R2: After a mode write and before a count is written, count edges have no effect and `tmr_out` stays high. The first count edge after a count write loads the count and leaves the output high.
- R3: In rate mode with count N, numbering the count edges from the one that loads the count as k=1, `tmr_out` is low after edge k exactly when (k-1) mod N = N-1. That is one low interval every N edges, with the first one N edges after the write.
- R4: In square mode with an even N, the output is high for N/2 count edges and then low for N/2 count edges, repeating. The first high phase starts at the load edge.
- R5: In square mode with an odd N, the output is high for (N+1)/2 count edges and low for (N-1)/2 count edges.
- R6: While `gate` is low, count edges do not advance the count, and a high output stays high.
- R7: If `gate` is low while `tmr_out` is low, `tmr_out` goes high in the next clock, with or without a count edge.
- R8: A rising edge of `gate` makes the next count edge reload the current initial count and restart the sequence, with the output high.
- R9: In rate mode, a count written while running leaves the current cycle unchanged. The new value is used from the next reload onward.
- R10: In square mode, a count written while running is used from the next half-cycle boundary onward.
- R11: A count written while running, followed by a gate rising edge, is loaded on the next count edge.
- R12: A count value of 0 acts as 65536.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | One-cycle strobe that writes the waveform mode |
| mode_sq | input | 1 | Mode value taken on `mode_wr`: 0 rate, 1 square |
| cnt_wr | input | 1 | One-cycle strobe that writes the initial count |
| cnt_data | input | CW | Initial count taken on `cnt_wr` (0 means 2^CW) |
| cnt_en | input | 1 | One-cycle count edge enable |
| gate | input | 1 | Gate: high enables counting, a rising edge restarts |
| tmr_out | output | 1 | Timer output |

## Verification
The assertions assume that a count of 1 is never written, and that `mode_wr` and `cnt_wr` never occur in the same cycle. Under those conditions, a rate-mode low pulse always ends on the next count edge, and a low gate can never leave the output low. The directed stimulus writes only counts of 2 or more. It changes `gate`, `mode_wr` and `cnt_wr` only in cycles where `cnt_en` is low, so every gate edge is registered before the count edge that consumes it.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } ivt_state_e;

    typedef enum logic {
        WAVE_RATE   = 1'b0,
        WAVE_SQUARE = 1'b1
    } ivt_wave_e;
endpackage

// File: rtl/ivt_gate_edge.sv
module ivt_gate_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    output logic gate_rise
);
    logic gate_q;

    // Reset value 1: a gate already high at reset does not count as a trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= 1'b1;
        else        gate_q <= gate;
    end

    assign gate_rise = gate && !gate_q;
endmodule

// File: rtl/ivt_reload_calc.sv
module ivt_reload_calc
    import ivt_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic [CW-1:0] init_cnt,
    input  ivt_wave_e     wave,
    input  logic          high_phase,
    output logic [CW:0]   reload_val
);
    localparam logic [CW:0] FULL_CNT = {1'b1, {CW{1'b0}}};

    logic [CW:0] eff_cnt;

    assign eff_cnt = (init_cnt == '0) ? FULL_CNT : {1'b0, init_cnt};

    // Square mode only ever counts even values; an odd N is split unevenly between phases.
    always_comb begin
        reload_val = eff_cnt;
        if (wave == WAVE_SQUARE && eff_cnt[0]) begin
            reload_val = high_phase ? eff_cnt + (CW+1)'(1) : eff_cnt - (CW+1)'(1);
        end
    end
endmodule

// File: rtl/ivt_wave_chan.sv
module ivt_wave_chan
    import ivt_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_wr,
    input  logic          mode_sq,
    input  logic          cnt_wr,
    input  logic [CW-1:0] cnt_data,
    input  logic          cnt_en,
    input  logic          gate,
    output logic          tmr_out
);
    localparam int EW = CW + 1;

    ivt_state_e    state_q, state_d;
    ivt_wave_e     wave_q;
    logic [CW-1:0] init_q;
    logic [EW-1:0] ce_q;
    logic [EW-1:0] rl_val;
    logic          out_q;
    logic          trig_q;
    logic          gate_rise;
    logic          edge_run, do_load, at_end, do_end, do_dec, rl_high;
    logic          chan_idle;
    logic          wave_is_sq;

    ivt_gate_edge u_gate_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate     (gate),
        .gate_rise(gate_rise)
    );

    ivt_reload_calc #(.CW(CW)) u_reload (
        .init_cnt  (init_q),
        .wave      (wave_q),
        .high_phase(rl_high),
        .reload_val(rl_val)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cnt_wr) state_d = ST_ARMED;
            ST_ARMED: if (cnt_en) state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_IDLE;
        endcase
        if (mode_wr) state_d = ST_IDLE;
    end

    // Per-edge decisions
    always_comb begin
        edge_run = cnt_en && (state_q == ST_RUN);
        do_load  = (cnt_en && (state_q == ST_ARMED)) || (edge_run && trig_q);
        at_end   = (wave_q == WAVE_RATE) ? (ce_q == EW'(1)) : (ce_q == EW'(2));
        do_end   = edge_run && !trig_q && gate && at_end;
        do_dec   = edge_run && !trig_q && gate && !at_end;
        rl_high  = do_end ? !out_q : 1'b1;
    end

    // Output and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave_q <= WAVE_RATE;
            init_q <= '0;
            ce_q   <= '0;
            out_q  <= 1'b1;
            trig_q <= 1'b0;
        end else if (mode_wr) begin
            wave_q <= mode_sq ? WAVE_SQUARE : WAVE_RATE;
            out_q  <= 1'b1;
            trig_q <= 1'b0;
        end else begin
            if (cnt_wr) init_q <= cnt_data;
            trig_q <= (trig_q && !(cnt_en && state_q != ST_IDLE)) || gate_rise;
            if (do_load) begin
                ce_q  <= rl_val;
                out_q <= 1'b1;
            end else if (do_end) begin
                ce_q  <= rl_val;
                out_q <= (wave_q == WAVE_RATE) ? 1'b1 : !out_q;
            end else if (do_dec) begin
                ce_q <= ce_q - ((wave_q == WAVE_RATE) ? EW'(1) : EW'(2));
                if (wave_q == WAVE_RATE && ce_q == EW'(2)) out_q <= 1'b0;
            end
            if (!gate && !out_q) out_q <= 1'b1;
        end
    end

    assign tmr_out    = out_q;
    assign chan_idle  = (state_q == ST_IDLE);
    assign wave_is_sq = (wave_q == WAVE_SQUARE);
endmodule

module ivt_wave_chan_chk (
    input logic clk,
    input logic rst_n,
    input logic mode_wr,
    input logic cnt_en,
    input logic gate,
    input logic tmr_out,
    input logic chan_idle,
    input logic wave_is_sq
);
    AST_MODE_FORCES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> tmr_out); // R1
    AST_IDLE_HOLDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        chan_idle |-> tmr_out); // R2
    AST_RATE_PULSE_ONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wave_is_sq && !tmr_out && cnt_en) |=> tmr_out); // R3
    AST_GATE_LOW_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate && cnt_en && tmr_out) |=> tmr_out); // R6
    AST_GATE_LOW_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate && !tmr_out) |=> tmr_out); // R7
    AST_NO_EDGE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && !cnt_en && !mode_wr) |=> $stable(tmr_out)); // R3
endmodule

bind ivt_wave_chan ivt_wave_chan_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_wr   (mode_wr),
    .cnt_en    (cnt_en),
    .gate      (gate),
    .tmr_out   (tmr_out),
    .chan_idle (chan_idle),
    .wave_is_sq(wave_is_sq)
);

// File: tb/ivt_wave_chan_test.sv
module ivt_wave_chan_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr = 1'b0;
    logic        mode_sq = 1'b0;
    logic        cnt_wr = 1'b0;
    logic [15:0] cnt_data = '0;
    logic        cnt_en = 1'b0;
    logic        gate = 1'b1;
    logic        tmr_out;

    int vecs = 0;
    int errs = 0;

    always #2 clk = ~clk;

    ivt_wave_chan #(.CW(16)) uut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_sq(mode_sq),
        .cnt_wr(cnt_wr), .cnt_data(cnt_data), .cnt_en(cnt_en),
        .gate(gate), .tmr_out(tmr_out)
    );

    task automatic chk(input logic exp, input string req, input int k);
        vecs++;
        if (tmr_out !== exp) begin
            errs++;
            $display("FAIL %s edge %0d: tmr_out actual=%b expected=%b", req, k, tmr_out, exp);
        end
    endtask

    function automatic logic exp_out(input bit sq, input int n, input int k);
        int eff = (n == 0) ? 65536 : n;
        int p = (k - 1) % eff;
        if (!sq) return (p != eff - 1);
        return (p < (eff + 1) / 2);
    endfunction

    task automatic set_mode(input bit sq);
        @(negedge clk); mode_wr = 1'b1; mode_sq = sq;
        @(negedge clk); mode_wr = 1'b0;
    endtask

    task automatic write_cnt(input int n);
        @(negedge clk); cnt_wr = 1'b1; cnt_data = 16'(n);
        @(negedge clk); cnt_wr = 1'b0;
    endtask

    task automatic step();
        @(negedge clk); cnt_en = 1'b1;
        @(negedge clk); cnt_en = 1'b0;
    endtask

    task automatic set_gate(input logic v);
        @(negedge clk); gate = v;
        @(negedge clk);
    endtask

    task automatic run_pattern(input bit sq, input int n, input int edges, input string req);
        set_mode(sq);
        write_cnt(n);
        for (int k = 1; k <= edges; k++) begin
            step();
            chk(exp_out(sq, n, k), req, k);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(1'b1, "R1 reset", 0);
    endtask

    task automatic t_idle();
        set_mode(1'b0);
        for (int k = 1; k <= 5; k++) begin
            step();
            chk(1'b1, "R2 no count", k);
        end
        write_cnt(2);
        step(); chk(1'b1, "R2 load edge", 1);
        step(); chk(1'b0, "R3 first low", 2);
    endtask

    task automatic t_rate();
        run_pattern(1'b0, 4, 12, "R3 N=4");
        run_pattern(1'b0, 2, 6,  "R3 N=2");
        run_pattern(1'b0, 7, 15, "R3 N=7");
    endtask

    task automatic t_mode_force();
        set_mode(1'b0);
        write_cnt(3);
        repeat (3) step();
        chk(1'b0, "R3 low before mode write", 3);
        set_mode(1'b0);
        chk(1'b1, "R1 mode write", 0);
    endtask

    task automatic t_square();
        run_pattern(1'b1, 6, 18, "R4 N=6");
        run_pattern(1'b1, 4, 8,  "R4 N=4");
        run_pattern(1'b1, 5, 15, "R5 N=5");
        run_pattern(1'b1, 3, 9,  "R5 N=3");
    endtask

    task automatic t_suspend();
        set_mode(1'b0);
        write_cnt(3);
        step();
        set_gate(1'b0);
        for (int k = 2; k <= 7; k++) begin
            step();
            chk(1'b1, "R6 gate low", k);
        end
        set_gate(1'b1);
        step(); chk(1'b1, "R8 retrigger load", 1);
        step(); chk(1'b1, "R8 retrigger", 2);
        step(); chk(1'b0, "R8 retrigger low", 3);
    endtask

    task automatic t_release();
        set_mode(1'b0);
        write_cnt(3);
        repeat (3) step();
        chk(1'b0, "R3 low before gate drop", 3);
        set_gate(1'b0);
        chk(1'b1, "R7 gate release", 0);
        set_gate(1'b1);
        step(); chk(1'b1, "R8 reload", 1);
        step(); chk(1'b1, "R8 reload", 2);
        step(); chk(1'b0, "R8 reload low", 3);
    endtask

    task automatic t_rewrite_rate();
        set_mode(1'b0);
        write_cnt(6);
        repeat (2) step();
        write_cnt(3);
        for (int k = 3; k <= 12; k++) begin
            step();
            chk((k == 6 || k == 9 || k == 12) ? 1'b0 : 1'b1, "R9 deferred rate", k);
        end
    endtask

    task automatic t_rewrite_trig();
        set_mode(1'b0);
        write_cnt(6);
        repeat (2) step();
        write_cnt(3);
        set_gate(1'b0);
        set_gate(1'b1);
        for (int k = 1; k <= 6; k++) begin
            step();
            chk(exp_out(1'b0, 3, k), "R11 rewrite with trigger", k);
        end
    endtask

    task automatic t_rewrite_sq();
        logic exp_seq [2:9];
        exp_seq = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
        set_mode(1'b1);
        write_cnt(8);
        step();
        write_cnt(4);
        for (int k = 2; k <= 9; k++) begin
            step();
            chk(exp_seq[k], "R10 deferred square", k);
        end
    endtask

    task automatic t_zero();
        set_mode(1'b0);
        write_cnt(0);
        @(negedge clk); cnt_en = 1'b1;
        repeat (65535) @(negedge clk);
        cnt_en = 1'b0;
        chk(1'b1, "R12 zero count", 65535);
        step(); chk(1'b0, "R12 zero count", 65536);
        step(); chk(1'b1, "R12 zero count", 65537);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_rate();
        t_mode_force();
        t_square();
        t_suspend();
        t_release();
        t_rewrite_rate();
        t_rewrite_trig();
        t_rewrite_sq();
        t_zero();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule